// File: doc/BRIEF.md
# Multi-Channel Pipe Command Front-End

This block is the register-level slave of a host-communication device that carries many independent byte channels. Software identifies a channel by a non-zero identifier and loads it into the identifier registers. For a transfer it also loads a buffer address and a byte length. A write to the command register then starts the operation. The block keeps a small table of open channels, each with two wait flags (waiting for readability, waiting for writability). It decides locally every command that only touches that table. It passes read, write and poll requests to a service model through a request/acknowledge port.

Each operation leaves a signed 32-bit result in the status register. A positive value is a byte count, zero means success or end-of-stream, and a negative value is an error code. Identifiers and buffer addresses wider than 32 bits are loaded in two writes: the upper word goes into a staging register first, and the write of the lower word commits the whole value. A read-only information register reports the table entry for the committed identifier. The table depth, identifier width, address width and page size are parameters.

Top module: `pipe_cmd_frontend`

## Requirements
- R1: After reset the status register reads 0, the information register reads 0, `busy` is 0 and `svc_req` is 0.
- R2: A write to the upper identifier word (offset 1) or upper address word (offset 3) only stages that word. The write to the lower word (offset 0 or 2) commits the full value, made of the staged upper word and the new lower word. Until that commit, commands keep using the previously committed value.
- R3: Any command whose committed identifier is zero gives status -1 (0xFFFFFFFF). It leaves the table unchanged and issues no service request.
- R4: Open (code 0) on an identifier that is not in the table, while a free entry exists, gives status 0 and makes the information register bit 0 (open) read 1. Open on an identifier already in the table gives -1. Open when all N_CH entries are in use gives -1.
- R5: Close, write, read, wake-on-write, wake-on-read or poll on a non-zero identifier that is not open gives status -3 (0xFFFFFFFD) and issues no service request.
- R6: Close (code 1) on an open identifier gives status 0, clears the entry (information register reads 0) and frees the entry so it can be opened again.
- R7: Wake-on-write (code 4) sets information bit 2 and wake-on-read (code 5) sets information bit 1 of an open channel. Each gives status 0. Open and close clear both bits.
- R8: Write buffer (code 2) and read buffer (code 3) check the page first. If (address mod 2^PAGE_BITS) + length exceeds 2^PAGE_BITS, the status is -1 and no request is made. Otherwise `svc_req` rises with `svc_op` equal to the command code and with the channel, address and length. These outputs hold steady until `svc_ack`.
- R9: In the cycle where `svc_req` and `svc_ack` are both high, `svc_result` is copied unchanged into the status register. This covers a positive count, 0 for end-of-stream and -2 (try again). `svc_req` and `busy` fall in the same cycle.
- R10: Poll (code 6) on an open channel issues a service request with op 6. The returned mask (bit 0 readable, bit 1 writable, bit 2 closed) becomes the status.
- R11: A command write made while `busy` is high is ignored: it changes neither the table nor the status.
- R12: A command value of 7 or more gives status -1 and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Word offset: 0 id low, 1 id high, 2 address low, 3 address high, 4 length, 5 command, 6 status, 7 channel info |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| busy | output | 1 | A service request is outstanding |
| svc_req | output | 1 | Service request valid |
| svc_op | output | 3 | Command code of the request |
| svc_chan | output | ID_W | Channel identifier of the request |
| svc_addr | output | BUF_AW | Buffer address of the request |
| svc_size | output | 32 | Byte length of the request |
| svc_ack | input | 1 | Service has answered |
| svc_result | input | 32 | Signed result from the service |

## Verification
Commands handled in the table (open, close, wake, errors) update the status and information registers at the same edge that captures the command write. The bench therefore reads them on the following negative clock edge, through the combinational read path. A forwarded command raises `svc_req` at that same edge. The result appears in the status register at the edge that samples `svc_ack`, and the bench drives the acknowledge on one negative edge and reads the status on the next. A behavioural model of the open set and the pending request is advanced by the bench tasks, and it is compared with `svc_req` a short delay after every rising edge.

// File: rtl/pipe_pkg.sv
package pipe_pkg;
   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] OFF_ID_LO   = 3'd0;
   localparam logic [REG_AW-1:0] OFF_ID_HI   = 3'd1;
   localparam logic [REG_AW-1:0] OFF_BUF_LO  = 3'd2;
   localparam logic [REG_AW-1:0] OFF_BUF_HI  = 3'd3;
   localparam logic [REG_AW-1:0] OFF_LEN     = 3'd4;
   localparam logic [REG_AW-1:0] OFF_CMD     = 3'd5;
   localparam logic [REG_AW-1:0] OFF_STATUS  = 3'd6;
   localparam logic [REG_AW-1:0] OFF_INFO    = 3'd7;

   typedef enum logic [2:0] {
      OP_OPEN   = 3'd0,
      OP_CLOSE  = 3'd1,
      OP_WRITE  = 3'd2,
      OP_READ   = 3'd3,
      OP_WAIT_W = 3'd4,
      OP_WAIT_R = 3'd5,
      OP_POLL   = 3'd6
   } pipe_op_e;

   localparam logic [31:0] ST_OK      = 32'd0;
   localparam logic [31:0] ST_INVALID = 32'hFFFF_FFFF;
   localparam logic [31:0] ST_AGAIN   = 32'hFFFF_FFFE;
   localparam logic [31:0] ST_NOCHAN  = 32'hFFFF_FFFD;
endpackage

// File: rtl/pipe_chan_table.sv
module pipe_chan_table #(
   parameter int N_CH = 8,
   parameter int ID_W = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ID_W-1:0]          lookup_id,
   output logic                     hit,
   output logic [$clog2(N_CH)-1:0]  hit_idx,
   output logic [2:0]               hit_flags,
   output logic                     free_ok,
   output logic [$clog2(N_CH)-1:0]  free_idx,
   input  logic                     alloc_en,
   input  logic                     rel_en,
   input  logic                     set_rd_en,
   input  logic                     set_wr_en
);
   localparam int IDX_W = $clog2(N_CH);

   logic [N_CH-1:0] vld;
   logic [N_CH-1:0] wait_rd;
   logic [N_CH-1:0] wait_wr;
   logic [ID_W-1:0] ids [N_CH];

   for (genvar i = 0; i < N_CH; i++) begin : g_ent
      logic            v_q, r_q, w_q;
      logic [ID_W-1:0] id_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q  <= 1'b0;
            r_q  <= 1'b0;
            w_q  <= 1'b0;
            id_q <= '0;
         end else if (alloc_en && free_idx == IDX_W'(i)) begin
            v_q  <= 1'b1;
            r_q  <= 1'b0;
            w_q  <= 1'b0;
            id_q <= lookup_id;
         end else if (rel_en && hit_idx == IDX_W'(i)) begin
            v_q <= 1'b0;
            r_q <= 1'b0;
            w_q <= 1'b0;
         end else begin
            if (set_rd_en && hit_idx == IDX_W'(i)) r_q <= 1'b1;
            if (set_wr_en && hit_idx == IDX_W'(i)) w_q <= 1'b1;
         end
      end
      assign vld[i]     = v_q;
      assign wait_rd[i] = r_q;
      assign wait_wr[i] = w_q;
      assign ids[i]     = id_q;
   end

   always_comb begin
      hit      = 1'b0;
      hit_idx  = '0;
      free_ok  = 1'b0;
      free_idx = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (!hit && vld[i] && ids[i] == lookup_id) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
         if (!free_ok && !vld[i]) begin
            free_ok  = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
      hit_flags = hit ? {wait_wr[hit_idx], wait_rd[hit_idx], 1'b1} : 3'b000;
   end
endmodule

// File: rtl/pipe_page_fit.sv
module pipe_page_fit #(
   parameter int BUF_AW    = 64,
   parameter int PAGE_BITS = 12
) (
   input  logic [BUF_AW-1:0] base,
   input  logic [31:0]       len,
   output logic              fits
);
   localparam logic [32:0] PAGE_BYTES = 33'(1) << PAGE_BITS;

   logic [32:0] end_off;
   assign end_off = {1'b0, len} + 33'(base[PAGE_BITS-1:0]);
   assign fits    = end_off <= PAGE_BYTES;
endmodule

// File: rtl/pipe_cmd_frontend.sv
module pipe_cmd_frontend
   import pipe_pkg::*;
#(
   parameter int N_CH      = 8,
   parameter int ID_W      = 64,
   parameter int BUF_AW    = 64,
   parameter int PAGE_BITS = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_AW-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               busy,
   output logic               svc_req,
   output logic [2:0]         svc_op,
   output logic [ID_W-1:0]    svc_chan,
   output logic [BUF_AW-1:0]  svc_addr,
   output logic [31:0]        svc_size,
   input  logic               svc_ack,
   input  logic [31:0]        svc_result
);
   if (N_CH < 2)                          begin : g_bad_depth $error("N_CH must be at least 2"); end
   if (ID_W < 1 || ID_W > 64)             begin : g_bad_id    $error("ID_W must be 1..64"); end
   if (BUF_AW < 32 || BUF_AW > 64)        begin : g_bad_aw    $error("BUF_AW must be 32..64"); end
   if (PAGE_BITS < 1 || PAGE_BITS > 31)   begin : g_bad_page  $error("PAGE_BITS must be 1..31"); end

   localparam int IDX_W = $clog2(N_CH);

   logic [ID_W-1:0]   chan_q, chan_commit;
   logic [BUF_AW-1:0] buf_q, buf_commit;
   logic [31:0]       len_q;
   logic [31:0]       status_q;

   wire wr_id_lo  = wr_en && addr == OFF_ID_LO;
   wire wr_buf_lo = wr_en && addr == OFF_BUF_LO;

   // Upper words are staged and only take effect with the lower-word write.
   if (ID_W > 32) begin : g_id_wide
      logic [ID_W-33:0] hi_stage;
      always_ff @(posedge clk) begin
         if (!rst_n) hi_stage <= '0;
         else if (wr_en && addr == OFF_ID_HI) hi_stage <= wdata[ID_W-33:0];
      end
      assign chan_commit = {hi_stage, wdata};
   end else begin : g_id_narrow
      assign chan_commit = wdata[ID_W-1:0];
   end

   if (BUF_AW > 32) begin : g_buf_wide
      logic [BUF_AW-33:0] hi_stage;
      always_ff @(posedge clk) begin
         if (!rst_n) hi_stage <= '0;
         else if (wr_en && addr == OFF_BUF_HI) hi_stage <= wdata[BUF_AW-33:0];
      end
      assign buf_commit = {hi_stage, wdata};
   end else begin : g_buf_narrow
      assign buf_commit = wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q <= '0;
         buf_q  <= '0;
         len_q  <= '0;
      end else begin
         if (wr_id_lo)                     chan_q <= chan_commit;
         if (wr_buf_lo)                    buf_q  <= buf_commit;
         if (wr_en && addr == OFF_LEN)     len_q  <= wdata;
      end
   end

   logic             hit, free_ok;
   logic [IDX_W-1:0] hit_idx, free_idx;
   logic [2:0]       hit_flags;
   logic             fits;
   logic             do_alloc, do_rel, do_set_rd, do_set_wr, do_launch;
   logic [31:0]      st_nxt;

   wire cmd_fire = wr_en && addr == OFF_CMD && !svc_req;

   pipe_chan_table #(.N_CH(N_CH), .ID_W(ID_W)) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .lookup_id (chan_q),
      .hit       (hit),
      .hit_idx   (hit_idx),
      .hit_flags (hit_flags),
      .free_ok   (free_ok),
      .free_idx  (free_idx),
      .alloc_en  (do_alloc),
      .rel_en    (do_rel),
      .set_rd_en (do_set_rd),
      .set_wr_en (do_set_wr)
   );

   pipe_page_fit #(.BUF_AW(BUF_AW), .PAGE_BITS(PAGE_BITS)) u_page (
      .base (buf_q),
      .len  (len_q),
      .fits (fits)
   );

   always_comb begin
      st_nxt    = ST_OK;
      do_alloc  = 1'b0;
      do_rel    = 1'b0;
      do_set_rd = 1'b0;
      do_set_wr = 1'b0;
      do_launch = 1'b0;
      if (wdata > 32'd6 || chan_q == '0) begin
         st_nxt = ST_INVALID;
      end else if (wdata[2:0] == OP_OPEN) begin
         if (hit || !free_ok) st_nxt = ST_INVALID;
         else                 do_alloc = cmd_fire;
      end else if (!hit) begin
         st_nxt = ST_NOCHAN;
      end else begin
         case (wdata[2:0])
            OP_CLOSE:          do_rel    = cmd_fire;
            OP_WAIT_W:         do_set_wr = cmd_fire;
            OP_WAIT_R:         do_set_rd = cmd_fire;
            OP_WRITE, OP_READ: begin
               if (fits) do_launch = cmd_fire;
               else      st_nxt    = ST_INVALID;
            end
            default:           do_launch = cmd_fire;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= ST_OK;
         svc_req  <= 1'b0;
         svc_op   <= '0;
         svc_chan <= '0;
         svc_addr <= '0;
         svc_size <= '0;
      end else if (cmd_fire) begin
         status_q <= st_nxt;
         if (do_launch) begin
            svc_req  <= 1'b1;
            svc_op   <= wdata[2:0];
            svc_chan <= chan_q;
            svc_addr <= buf_q;
            svc_size <= len_q;
         end
      end else if (svc_req && svc_ack) begin
         svc_req  <= 1'b0;
         status_q <= svc_result;
      end
   end

   assign busy = svc_req;

   logic [63:0] chan_ext, buf_ext;
   assign chan_ext = 64'(chan_q);
   assign buf_ext  = 64'(buf_q);

   always_comb begin
      case (addr)
         OFF_ID_LO:  rdata = chan_ext[31:0];
         OFF_ID_HI:  rdata = chan_ext[63:32];
         OFF_BUF_LO: rdata = buf_ext[31:0];
         OFF_BUF_HI: rdata = buf_ext[63:32];
         OFF_LEN:    rdata = len_q;
         OFF_STATUS: rdata = status_q;
         OFF_INFO:   rdata = {29'd0, hit_flags};
         default:    rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/pipe_cmd_frontend_chk.sv
module pipe_cmd_frontend_chk #(
   parameter int ID_W      = 64,
   parameter int BUF_AW    = 64,
   parameter int PAGE_BITS = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [2:0]        addr,
   input logic              busy,
   input logic              svc_req,
   input logic [2:0]        svc_op,
   input logic [ID_W-1:0]   svc_chan,
   input logic [BUF_AW-1:0] svc_addr,
   input logic [31:0]       svc_size,
   input logic              svc_ack,
   input logic [31:0]       svc_result,
   input logic [31:0]       status_q
);
   logic [32:0] req_end;
   assign req_end = {1'b0, svc_size} + 33'(svc_addr[PAGE_BITS-1:0]);

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      !rst_n |=> !svc_req && status_q == 32'd0);

   // R3
   req_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> svc_chan != '0);

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req && !svc_ack |=> svc_req && $stable(svc_op) && $stable(svc_chan)
                              && $stable(svc_addr) && $stable(svc_size));

   // R8
   req_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req && (svc_op == 3'd2 || svc_op == 3'd3) |-> req_end <= (33'(1) << PAGE_BITS));

   // R10
   req_op_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req |-> svc_op == 3'd2 || svc_op == 3'd3 || svc_op == 3'd6);

   // R9
   req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      svc_req && svc_ack |=> !svc_req && !busy && status_q == $past(svc_result));

   // R11
   busy_cmd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !svc_ack && wr_en && addr == 3'd5 |=> $stable(status_q) && svc_req);
endmodule

bind pipe_cmd_frontend pipe_cmd_frontend_chk #(
   .ID_W(ID_W), .BUF_AW(BUF_AW), .PAGE_BITS(PAGE_BITS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .addr       (addr),
   .busy       (busy),
   .svc_req    (svc_req),
   .svc_op     (svc_op),
   .svc_chan   (svc_chan),
   .svc_addr   (svc_addr),
   .svc_size   (svc_size),
   .svc_ack    (svc_ack),
   .svc_result (svc_result),
   .status_q   (status_q)
);

// File: tb/test_pipe_cmd_frontend.sv
module test_pipe_cmd_frontend;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic        busy, svc_req, svc_ack = 1'b0;
   logic [2:0]  svc_op;
   logic [63:0] svc_chan, svc_addr;
   logic [31:0] svc_size;
   logic [31:0] svc_result = 32'd0;

   always #5 clk = ~clk;

   pipe_cmd_frontend i_pipe_cmd_frontend (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .busy(busy), .svc_req(svc_req), .svc_op(svc_op),
      .svc_chan(svc_chan), .svc_addr(svc_addr), .svc_size(svc_size),
      .svc_ack(svc_ack), .svc_result(svc_result)
   );

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 0;

   // behavioural model state
   logic [63:0] id_stage = 0, id_cur = 0, buf_stage = 0, buf_cur = 0;
   logic [31:0] len_cur = 0;
   logic [63:0] open_q[$];
   bit          f_rd[logic [63:0]];
   bit          f_wr[logic [63:0]];
   bit          exp_req = 0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) check("R9 svc_req per-cycle", 64'(svc_req), 64'(exp_req));
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_id(input logic [31:0] hi, input logic [31:0] lo);
      wr(3'd1, hi); id_stage[63:32] = hi;
      wr(3'd0, lo); id_cur = {id_stage[63:32], lo};
   endtask

   task automatic set_buf(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] len);
      wr(3'd3, hi); buf_stage[63:32] = hi;
      wr(3'd2, lo); buf_cur = {buf_stage[63:32], lo};
      wr(3'd4, len); len_cur = len;
   endtask

   function automatic int find_open(input logic [63:0] id);
      foreach (open_q[i]) if (open_q[i] == id) return i;
      return -1;
   endfunction

   function automatic void model(input int code, output logic [31:0] st, output bit svc);
      int k;
      svc = 0; st = 0;
      k = find_open(id_cur);
      if (code > 6 || id_cur == 0) st = 32'hFFFF_FFFF;
      else if (code == 0) begin
         if (k >= 0 || open_q.size() >= 8) st = 32'hFFFF_FFFF;
         else begin open_q.push_back(id_cur); f_rd[id_cur] = 0; f_wr[id_cur] = 0; end
      end else if (k < 0) st = 32'hFFFF_FFFD;
      else if (code == 1) begin open_q.delete(k); f_rd[id_cur] = 0; f_wr[id_cur] = 0; end
      else if (code == 4) f_wr[id_cur] = 1;
      else if (code == 5) f_rd[id_cur] = 1;
      else if (code == 6) svc = 1;
      else if ((buf_cur % 4096) + 64'(len_cur) > 4096) st = 32'hFFFF_FFFF;
      else svc = 1;
   endfunction

   function automatic logic [31:0] exp_info();
      if (find_open(id_cur) < 0) return 0;
      return {29'd0, f_wr[id_cur], f_rd[id_cur], 1'b1};
   endfunction

   // Issue a command; if forwarded, answer after dly cycles with res.
   // intrude: write a close command while the request is pending.
   task automatic cmd(input string tag, input int code, input logic [31:0] res,
                      input int dly, input bit intrude);
      logic [31:0] st;
      bit svc;
      model(code, st, svc);
      exp_req = svc;
      wr(3'd5, 32'(code));
      if (svc) begin
         check({tag, " svc_op"}, 64'(svc_op), 64'(code));
         check({tag, " svc_chan"}, svc_chan, id_cur);
         if (code != 6) begin
            check({tag, " svc_addr"}, svc_addr, buf_cur);
            check({tag, " svc_size"}, 64'(svc_size), 64'(len_cur));
         end
         if (intrude) begin
            wr(3'd5, 32'd1);
            check("R11 busy during ignored cmd", 64'(busy), 64'd1);
         end
         for (int i = 0; i < dly; i++) @(negedge clk);
         svc_ack = 1'b1; svc_result = res; exp_req = 0;
         @(negedge clk);
         svc_ack = 1'b0;
         st = res;
      end else begin
         check({tag, " no request"}, 64'(svc_req), 64'd0);
      end
      addr = 3'd6; #1;
      check({tag, " status"}, 64'(rdata), 64'(st));
      addr = 3'd7; #1;
      check({tag, " info"}, 64'(rdata), 64'(exp_info()));
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      addr = 3'd6; #1;
      check("R1 reset status", 64'(rdata), 64'd0);
      addr = 3'd7; #1;
      check("R1 reset info", 64'(rdata), 64'd0);
      check("R1 reset busy", 64'(busy), 64'd0);
      check("R1 reset svc_req", 64'(svc_req), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      set_id(32'h1, 32'h5);
      cmd("R4 open new", 0, 0, 0, 0);
      cmd("R4 open twice", 0, 0, 0, 0);
      set_id(32'h0, 32'h0);
      cmd("R3 open zero", 0, 0, 0, 0);
      cmd("R3 read zero", 3, 0, 0, 0);
      set_id(32'h0, 32'h7);
      cmd("R5 close unknown", 1, 0, 0, 0);
      cmd("R5 poll unknown", 6, 0, 0, 0);
      set_id(32'h1, 32'h5);
      cmd("R7 wait read", 5, 0, 0, 0);
      cmd("R7 wait write", 4, 0, 0, 0);

      set_buf(32'hA, 32'h1000_0F00, 32'h100);
      cmd("R8 write fits page", 2, 32'h100, 2, 0);
      set_buf(32'hA, 32'h1000_0F00, 32'h101);
      cmd("R8 read crosses page", 3, 0, 0, 0);
      set_buf(32'h0, 32'h0000_2000, 32'h1000);
      cmd("R9 read again code", 3, 32'hFFFF_FFFE, 3, 0);
      cmd("R9 read end of stream", 3, 32'h0, 0, 0);
      cmd("R10 poll mask", 6, 32'h5, 1, 0);
      cmd("R11 write with close during busy", 2, 32'h40, 2, 1);
      cmd("R11 channel still open", 4, 0, 0, 0);

      // R2: staging the upper word alone leaves the committed id unchanged
      wr(3'd1, 32'h9); id_stage[63:32] = 32'h9;
      addr = 3'd1; #1;
      check("R2 id high unchanged before commit", 64'(rdata), 64'h1);
      @(negedge clk);
      cmd("R2 close uses committed id", 1, 0, 0, 0);
      wr(3'd0, 32'h5); id_cur = {id_stage[63:32], 32'h5};
      addr = 3'd1; #1;
      check("R2 id high after commit", 64'(rdata), 64'h9);
      @(negedge clk);
      cmd("R2 open new id", 0, 0, 0, 0);
      set_id(32'h1, 32'h5);
      cmd("R6 reopen after close", 0, 0, 0, 0);
      cmd("R7 flags cleared on open", 2, 32'h0, 0, 0);
      cmd("R12 bad code", 7, 0, 0, 0);

      for (int i = 0; i < 7; i++) begin
         set_id(32'h0, 32'h100 + 32'(i));
         cmd("R4 fill table", 0, 0, 0, 0);
      end
      check("R4 model table full", 64'(open_q.size()), 64'd8);
      set_id(32'h0, 32'h200);
      cmd("R4 open when full", 0, 0, 0, 0);
      set_id(32'h0, 32'h103);
      cmd("R6 close in full table", 1, 0, 0, 0);
      set_id(32'h0, 32'h200);
      cmd("R6 open into freed entry", 0, 0, 0, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule